// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the write-side command interpreter of a byte-wide parallel NOR flash model that follows the AMD-style command protocol. Every bus write (byte offset plus data byte) is fed to it. It follows the two-write unlock handshake and decodes the command that comes after it. It then issues single-cycle modify requests to the storage array: program one byte, erase one sector, or erase the whole chip. It also tells the read path which view to present: array data, identification data, or the query table.

Unlock addresses are compared against the offset within a sector, so they repeat in every sector. Erases keep the block busy for a parameterized number of clock cycles. While the erase is busy, every write is ignored. A one-cycle done strobe marks the end of the erase. An unlock-bypass mode lets software program bytes with a single command write each, without repeating the unlock pair.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, mode is 0 (array read), busy and done are 0, mem_op is 0 (none) and status is 0xFF.
- R2: In the idle state, only data 0xAA at sector offset UNLOCK0 starts a sequence; any other first write leaves the block idle.
- R3: The second write must be data 0x55 at sector offset UNLOCK1, otherwise the block returns to idle.
- R4: The command write must hit sector offset UNLOCK0, unless bypass is active. Command 0x90 selects identification mode (mode = 1).
- R5: After command 0xA0, the next write produces a one-cycle mem_op = 1 (program) request carrying that write's offset and data. The storage clears the bits where the data is 0. The block then returns to idle, or to the command stage if bypass is active.
- R6: After a program, status is 0x7F with bit 7 replaced by the inverse of bit 7 of the programmed data.
- R7: Data 0xF0 returns the block to idle from any state except the program data cycle and an active erase. In the program data cycle, 0xF0 is programmed as ordinary data.
- R8: Data 0x98 at sector offset 0x55 enters query mode (mode = 2), either from idle or from identification mode. Any write while in query mode returns the block to mode 0.
- R9: Command 0x20 enters bypass. In bypass, commands are accepted at any offset and 0xA0 programs without an unlock pair. The sequence 0x90 then 0x00 leaves bypass.
- R10: The erase path is 0x80, then 0xAA at UNLOCK0, then 0x55 at UNLOCK1. After it, 0x10 at UNLOCK0 issues mem_op = 3 (chip erase) with offset 0 and data 0xFF, and busy stays high for CHIP_CYC cycles. 0x10 at any other offset aborts without a request.
- R11: On the same path, 0x30 at any offset issues mem_op = 2 (sector erase) with the offset rounded down to a sector boundary, and busy stays high for SECT_CYC cycles.
- R12: done is high for exactly the last busy cycle. While busy, all writes are ignored, including 0xF0, and status is 0x00. Once done, status reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_ofs | input | OFS_W | Byte offset of the write |
| wr_data | input | 8 | Write data byte |
| mem_op | output | 2 | Storage request: 0 none, 1 program, 2 sector erase, 3 chip erase |
| mem_ofs | output | OFS_W | Request offset (sector base for erase) |
| mem_data | output | 8 | Program mask data, 0xFF for erases |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle erase completion strobe |
| status | output | 8 | Status byte for the read path |
| mode | output | 2 | Read view: 0 array, 1 identification, 2 query |

## Verification
The bench uses OFS_W=10 and SECT_W=8, so there are four sectors of 256 bytes. The unlock offsets are 0xA5 and 0x5A, and the erases last 12 and 40 cycles. With sectors this small, every byte value can be swept through the first and second unlock stage, and every sector offset through the command stage. The short erase windows make it possible to check every cycle of busy and done and to interleave writes that must be ignored. Bypass entry and exit, aligned sector erase and the address check on chip erase are covered with computed offsets.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_ID    = 2'd1,
        MODE_QUERY = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } mem_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_UNL2, ST_CMD, ST_PROG, ST_ID,
        ST_ER1, ST_ER2, ST_ERCF, ST_BUSY, ST_QUERY, ST_BYPX
    } seq_st_e;

    localparam logic [7:0] C_RESET   = 8'hF0;
    localparam logic [7:0] C_UNL_A   = 8'hAA;
    localparam logic [7:0] C_UNL_B   = 8'h55;
    localparam logic [7:0] C_QUERY   = 8'h98;
    localparam logic [7:0] C_PROG    = 8'hA0;
    localparam logic [7:0] C_ERASE   = 8'h80;
    localparam logic [7:0] C_CHIP    = 8'h10;
    localparam logic [7:0] C_SECT    = 8'h30;
    localparam logic [7:0] C_ID      = 8'h90;
    localparam logic [7:0] C_BYP     = 8'h20;
    localparam logic [7:0] C_BYPX    = 8'h00;
    localparam logic [7:0] QUERY_OFS = 8'h55;

    localparam logic [7:0] STAT_IDLE  = 8'hFF;
    localparam logic [7:0] STAT_ERASE = 8'h00;

    // data-polling status after a program
    function automatic logic [7:0] poll_status(input logic [7:0] d);
        return {~d[7], 7'h7F};
    endfunction

endpackage

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
    parameter int CHIP_CYC = 1000,
    parameter int SECT_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start_sect,
    input  logic start_chip,
    output logic busy,
    output logic done
);
    localparam int MAX_CYC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start_chip) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(CHIP_CYC);
        end else if (start_sect) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(SECT_CYC);
        end else if (busy) begin
            if (cnt == CNT_W'(1)) busy <= 1'b0;
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = busy && (cnt == CNT_W'(1));

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int              OFS_W   = 16,
    parameter int              SECT_W  = 12,
    parameter logic [SECT_W-1:0] UNLOCK0 = SECT_W'(12'h555),
    parameter logic [SECT_W-1:0] UNLOCK1 = SECT_W'(12'h2AA)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [7:0]       wr_data,
    input  logic             erase_done,
    output logic             start_sect,
    output logic             start_chip,
    output mem_op_e          op_q,
    output logic [OFS_W-1:0] ofs_q,
    output logic [7:0]       dat_q,
    output logic [7:0]       stat_q,
    output rd_mode_e         mode
);
    seq_st_e          st, st_n;
    logic             byp, byp_n;
    mem_op_e          op_n;
    logic [OFS_W-1:0] ofs_n;
    logic [7:0]       dat_n, stat_n;

    logic [SECT_W-1:0] sofs;
    logic              hit0, hit1, hitq;

    assign sofs = wr_ofs[SECT_W-1:0];
    assign hit0 = (sofs == UNLOCK0);
    assign hit1 = (sofs == UNLOCK1);
    assign hitq = (sofs == SECT_W'(QUERY_OFS));

    always_comb begin
        st_n       = st;
        byp_n      = byp;
        op_n       = OP_NONE;
        ofs_n      = ofs_q;
        dat_n      = dat_q;
        stat_n     = stat_q;
        start_sect = 1'b0;
        start_chip = 1'b0;
        if (st == ST_BUSY) begin
            if (erase_done) begin
                st_n   = byp ? ST_CMD : ST_IDLE;
                stat_n = STAT_IDLE;
            end
        end else if (wr_en) begin
            if (wr_data == C_RESET && st != ST_PROG) begin
                st_n = ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (hitq && wr_data == C_QUERY)      st_n = ST_QUERY;
                        else if (hit0 && wr_data == C_UNL_A) st_n = ST_UNL2;
                    end
                    ST_UNL2: st_n = (hit1 && wr_data == C_UNL_B) ? ST_CMD : ST_IDLE;
                    ST_CMD: begin
                        if (!hit0 && !byp) st_n = ST_IDLE;
                        else begin
                            case (wr_data)
                                C_PROG:  st_n = ST_PROG;
                                C_ERASE: st_n = ST_ER1;
                                C_ID:    st_n = byp ? ST_BYPX : ST_ID;
                                C_BYP: begin
                                    byp_n = 1'b1;
                                    st_n  = ST_CMD;
                                end
                                default: st_n = ST_IDLE;
                            endcase
                        end
                    end
                    ST_PROG: begin
                        op_n   = OP_PROG;
                        ofs_n  = wr_ofs;
                        dat_n  = wr_data;
                        stat_n = poll_status(wr_data);
                        st_n   = byp ? ST_CMD : ST_IDLE;
                    end
                    ST_ID:  st_n = (hitq && wr_data == C_QUERY) ? ST_QUERY : ST_IDLE;
                    ST_ER1: st_n = (hit0 && wr_data == C_UNL_A) ? ST_ER2 : ST_IDLE;
                    ST_ER2: st_n = (hit1 && wr_data == C_UNL_B) ? ST_ERCF : ST_IDLE;
                    ST_ERCF: begin
                        if (wr_data == C_CHIP && hit0) begin
                            op_n       = OP_CHIP;
                            ofs_n      = '0;
                            dat_n      = 8'hFF;
                            stat_n     = STAT_ERASE;
                            start_chip = 1'b1;
                            st_n       = ST_BUSY;
                        end else if (wr_data == C_SECT) begin
                            op_n       = OP_SECT;
                            ofs_n      = {wr_ofs[OFS_W-1:SECT_W], {SECT_W{1'b0}}};
                            dat_n      = 8'hFF;
                            stat_n     = STAT_ERASE;
                            start_sect = 1'b1;
                            st_n       = ST_BUSY;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                    ST_BYPX: st_n = (wr_data == C_BYPX) ? ST_IDLE : ST_CMD;
                    default: st_n = ST_IDLE;
                endcase
            end
        end
        if (st_n == ST_IDLE) byp_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            byp    <= 1'b0;
            op_q   <= OP_NONE;
            ofs_q  <= '0;
            dat_q  <= '0;
            stat_q <= STAT_IDLE;
        end else begin
            st     <= st_n;
            byp    <= byp_n;
            op_q   <= op_n;
            ofs_q  <= ofs_n;
            dat_q  <= dat_n;
            stat_q <= stat_n;
        end
    end

    always_comb begin
        case (st)
            ST_ID:    mode = MODE_ID;
            ST_QUERY: mode = MODE_QUERY;
            default:  mode = MODE_ARRAY;
        endcase
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int                OFS_W    = 16,
    parameter int                SECT_W   = 12,
    parameter logic [SECT_W-1:0] UNLOCK0  = SECT_W'(12'h555),
    parameter logic [SECT_W-1:0] UNLOCK1  = SECT_W'(12'h2AA),
    parameter int                CHIP_CYC = 5000,
    parameter int                SECT_CYC = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [7:0]       wr_data,
    output logic [1:0]       mem_op,
    output logic [OFS_W-1:0] mem_ofs,
    output logic [7:0]       mem_data,
    output logic             busy,
    output logic             done,
    output logic [7:0]       status,
    output logic [1:0]       mode
);
    logic     start_sect, start_chip;
    mem_op_e  op_q;
    rd_mode_e mode_q;

    nor_cmd_fsm #(
        .OFS_W(OFS_W), .SECT_W(SECT_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)
    ) u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
        .erase_done(done), .start_sect(start_sect), .start_chip(start_chip),
        .op_q(op_q), .ofs_q(mem_ofs), .dat_q(mem_data), .stat_q(status),
        .mode(mode_q)
    );

    nor_erase_timer #(
        .CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC)
    ) u_timer (
        .clk(clk), .rst(rst), .start_sect(start_sect), .start_chip(start_chip),
        .busy(busy), .done(done)
    );

    assign mem_op = op_q;
    assign mode   = mode_q;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int OFS_W  = 16,
    parameter int SECT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mem_op,
    input logic [OFS_W-1:0] mem_ofs,
    input logic [7:0]       mem_data,
    input logic             busy,
    input logic             done,
    input logic [7:0]       status,
    input logic [1:0]       mode
);
    // R12
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> busy);
    // R12
    done_clears_chk: assert property (@(posedge clk) disable iff (rst) done |=> !busy);
    // R12
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> (mem_op == 2'd0));
    // R5
    op_pulse_chk: assert property (@(posedge clk) disable iff (rst) (mem_op != 2'd0) |=> (mem_op == 2'd0));
    // R6
    poll_bit_chk: assert property (@(posedge clk) disable iff (rst) (mem_op == 2'd1) |-> (status[7] == ~mem_data[7]));
    // R11
    sect_align_chk: assert property (@(posedge clk) disable iff (rst) (mem_op == 2'd2) |-> (mem_ofs[SECT_W-1:0] == '0));
    // R10
    chip_base_chk: assert property (@(posedge clk) disable iff (rst) (mem_op == 2'd3) |-> (mem_ofs == '0 && mem_data == 8'hFF));
    // R10
    erase_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_op[1] |-> (busy && status == 8'h00));
    // R8
    mode_range_chk: assert property (@(posedge clk) disable iff (rst) mode != 2'd3);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.OFS_W(OFS_W), .SECT_W(SECT_W)) u_chk (
    .clk(clk), .rst(rst), .mem_op(mem_op), .mem_ofs(mem_ofs), .mem_data(mem_data),
    .busy(busy), .done(done), .status(status), .mode(mode)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
    localparam int         OFS_W  = 10;
    localparam int         SECT_W = 8;
    localparam logic [9:0] U0     = 10'h0A5;
    localparam logic [9:0] U1     = 10'h05A;
    localparam int         CHIP   = 40;
    localparam int         SECT   = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [OFS_W-1:0] wr_ofs = '0;
    logic [7:0]       wr_data = '0;
    logic [1:0]       mem_op;
    logic [OFS_W-1:0] mem_ofs;
    logic [7:0]       mem_data;
    logic             busy, done;
    logic [7:0]       status;
    logic [1:0]       mode;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    nor_cmd_seq #(
        .OFS_W(OFS_W), .SECT_W(SECT_W), .UNLOCK0(8'hA5), .UNLOCK1(8'h5A),
        .CHIP_CYC(CHIP), .SECT_CYC(SECT)
    ) u_nor_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
        .mem_op(mem_op), .mem_ofs(mem_ofs), .mem_data(mem_data),
        .busy(busy), .done(done), .status(status), .mode(mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] o, input logic [7:0] d);
        wr_en = 1'b1; wr_ofs = o; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(U0, 8'hAA);
        wr(U1, 8'h55);
    endtask

    task automatic erase_window(input int n, input string tag);
        for (int j = 1; j <= n; j++) begin
            wr_en   = (j <= 3);
            wr_ofs  = (j == 2) ? U0 : 10'h000;
            wr_data = (j == 1) ? 8'hF0 : ((j == 2) ? 8'hAA : 8'hA0);
            @(negedge clk);
            chk({tag, " busy"}, busy, (j < n) ? 1 : 0);
            chk({tag, " done"}, done, (j == n - 1) ? 1 : 0);
            chk({tag, " R12 quiet"}, mem_op, 0);
            if (j < n) chk({tag, " R12 status busy"}, status, 8'h00);
        end
        wr_en = 1'b0;
        chk({tag, " R12 status after"}, status, 8'hFF);
        // the AA written while busy must not have counted
        wr(U1, 8'h55);
        wr(U0, 8'h90);
        chk({tag, " R12 writes ignored"}, mode, 0);
        wr(10'h000, 8'hF0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_op", mem_op, 0);
        chk("R1 status", status, 8'hFF);
        rst = 1'b0;
        @(negedge clk);

        // R2 sweep first-cycle data
        for (int d = 0; d < 256; d++) begin
            wr(U0, 8'(d));
            wr(U1, 8'h55);
            wr(U0, 8'h90);
            chk("R2 first unlock data", mode, (d == 8'hAA) ? 1 : 0);
            wr(10'h000, 8'hF0);
        end
        // R3 sweep second-cycle data
        for (int d = 0; d < 256; d++) begin
            wr(U0, 8'hAA);
            wr(U1, 8'(d));
            wr(U0, 8'h90);
            chk("R3 second unlock data", mode, (d == 8'h55) ? 1 : 0);
            wr(10'h000, 8'hF0);
        end
        // R4 sweep command offset (sector offset, upper bits vary)
        for (int a = 0; a < 256; a++) begin
            unlock();
            wr(10'((a % 4) << 8 | a), 8'h90);
            chk("R4 command offset", mode, (a == 8'hA5) ? 1 : 0);
            // R7 abort from identification mode
            wr(10'h000, 8'hF0);
            chk("R7 abort to array", mode, 0);
        end

        // R8 query entry from idle and from identification
        wr(10'h055, 8'h98);
        chk("R8 query from idle", mode, 2);
        wr(10'h055, 8'h00);
        chk("R8 write leaves query", mode, 0);
        unlock();
        wr(U0, 8'h90);
        chk("R8 id mode", mode, 1);
        wr(10'h155, 8'h98);
        chk("R8 query from id", mode, 2);
        wr(10'h000, 8'h12);
        chk("R8 leave query", mode, 0);

        // R5 R6 program sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            logic [9:0] o;
            d = 8'((i * 8'h47) ^ 8'h3C);
            o = 10'((i * 37 + 5) % 1024);
            unlock();
            wr(U0, 8'hA0);
            wr(o, d);
            chk("R5 program op", mem_op, 1);
            chk("R5 program ofs", mem_ofs, o);
            chk("R5 program data", mem_data, d);
            chk("R6 poll status", status, {~d[7], 7'h7F});
            @(negedge clk);
            chk("R5 one-cycle pulse", mem_op, 0);
        end
        // R7 F0 as program data
        unlock();
        wr(U0, 8'hA0);
        wr(10'h123, 8'hF0);
        chk("R7 F0 programmed op", mem_op, 1);
        chk("R7 F0 programmed data", mem_data, 8'hF0);
        chk("R6 poll status F0", status, 8'h7F);

        // R9 bypass
        unlock();
        wr(U0, 8'h20);
        wr(10'h3F3, 8'hA0);
        wr(10'h213, 8'h0F);
        chk("R9 bypass program op", mem_op, 1);
        chk("R9 bypass program ofs", mem_ofs, 10'h213);
        wr(10'h001, 8'hA0);
        wr(10'h002, 8'h81);
        chk("R9 second bypass program", mem_op, 1);
        chk("R9 second bypass data", mem_data, 8'h81);
        wr(10'h007, 8'h90);
        chk("R9 exit step not id", mode, 0);
        wr(10'h009, 8'h00);
        wr(10'h3F3, 8'hA0);
        wr(10'h010, 8'h11);
        chk("R9 bypass left", mem_op, 0);

        // R11 sector erase
        unlock();
        wr(U0, 8'h80);
        unlock();
        wr(10'h2C7, 8'h30);
        chk("R11 sector op", mem_op, 2);
        chk("R11 sector base", mem_ofs, 10'h200);
        chk("R11 sector data", mem_data, 8'hFF);
        chk("R11 busy", busy, 1);
        erase_window(SECT, "R11");

        // R10 chip erase with wrong confirm offset
        unlock();
        wr(U0, 8'h80);
        unlock();
        wr(10'h0A6, 8'h10);
        chk("R10 bad confirm op", mem_op, 0);
        chk("R10 bad confirm busy", busy, 0);
        // R10 chip erase proper (sector offset matches UNLOCK0)
        unlock();
        wr(U0, 8'h80);
        unlock();
        wr(10'h1A5, 8'h10);
        chk("R10 chip op", mem_op, 3);
        chk("R10 chip ofs", mem_ofs, 0);
        chk("R10 chip data", mem_data, 8'hFF);
        chk("R10 busy", busy, 1);
        erase_window(CHIP, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule